// File: doc/BRIEF.md
# DRAM Auto-Refresh Command Sequencer

This block drives the command pins of a mobile DDR SDRAM controller through one refresh episode. When the controller raises a refresh request, the sequencer looks at whether any bank is still open. If one is, it closes every bank with a precharge-all command, which is a PRECHARGE with A10 high. It then waits the row-precharge time and issues one or more AUTO REFRESH commands. After each AUTO REFRESH it holds the bus quiet for the refresh-cycle time.

Each AUTO REFRESH is a single, non-persistent command, so a chain of N refreshes puts N separate commands on the bus. When the refresh-cycle time of the final command has elapsed, the block pulses `done_o` for one cycle. From that cycle on, the controller may issue ACTIVE. Clock enable stays high throughout. The precharge and refresh waits are set by the parameters `T_RP` and `T_RFC`, both in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a sequence, returns the block to idle. In idle it drives NOP on the command bus, CKE high, A10 low and `done_o` low. The command bus is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001.
- R2: If `bank_open_i` is high when a request is accepted, the cycle after acceptance carries PRECHARGE with A10 high.
- R3: The first AUTO REFRESH comes exactly `T_RP` cycles after the PRECHARGE, and every cycle in between carries NOP.
- R4: If `bank_open_i` is low when a request is accepted, no PRECHARGE is issued, and the first AUTO REFRESH appears in the cycle after acceptance.
- R5: After each AUTO REFRESH, the next `T_RFC`-1 cycles carry NOP.
- R6: A count N sampled at acceptance produces exactly N AUTO REFRESH commands, spaced exactly `T_RFC` cycles apart. A count of 0 produces one.
- R7: `done_o` is a single-cycle pulse exactly `T_RFC` cycles after the last AUTO REFRESH. In that cycle the block is idle again and drives NOP.
- R8: A request is accepted only in idle. Changes on `req_i`, `count_i` and `bank_open_i` while a sequence runs do not alter that sequence.
- R9: CKE is high in every cycle.
- R10: A10 is low in every cycle that does not carry PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Refresh request, taken only in idle |
| bank_open_i | input | 1 | High when at least one bank is open |
| count_i | input | CNT_W | Number of refreshes to chain (0 means one) |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| a10_o | output | 1 | Address bit 10, high for precharge-all |
| cke_o | output | 1 | Clock enable |
| done_o | output | 1 | One-cycle pulse when ACTIVE may follow |

## Verification
The assertions assume that reset is applied at time zero, so their window counters start from a quiet bus. They also assume that `bank_open_i` correctly reflects the banks when a request is accepted. The stimulus meets both conditions: reset is held for the first cycles, and every request is presented in idle with a settled bank flag. Changes to the request inputs occur only at falling edges during a running sequence, which exercises the ignore rule without breaking those assumptions.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'b0111,
      CMD_PRE  = 4'b0010,
      CMD_AREF = 4'b0001,
      CMD_DESL = 4'b1111
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WAIT_RP,
      ST_AREF,
      ST_WAIT_RFC
   } seq_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refseq_timer.sv
module refseq_timer #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             expired
);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/refseq_fsm.sv
module refseq_fsm
   import refseq_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 5,
   parameter int CNT_W = 4,
   parameter int TW    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             bank_open,
   input  logic [CNT_W-1:0] count,
   input  logic             t_expired,
   output logic             t_load,
   output logic [TW-1:0]    t_val,
   output seq_state_e       state,
   output logic             done
);

   localparam bit RP_SHORT  = (T_RP  == 1);
   localparam bit RFC_SHORT = (T_RFC == 1);
   localparam logic [TW-1:0] RP_LD  = RP_SHORT  ? '0 : TW'(T_RP  - 2);
   localparam logic [TW-1:0] RFC_LD = RFC_SHORT ? '0 : TW'(T_RFC - 2);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] rem_q;
   logic             done_q;
   logic             accept;
   logic             rfc_end;
   logic             last;

   assign accept  = (state_q == ST_IDLE) && req;
   assign last    = (rem_q == '0);
   assign rfc_end = ((state_q == ST_AREF) && RFC_SHORT) ||
                    ((state_q == ST_WAIT_RFC) && t_expired);

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) state_d = bank_open ? ST_PRE : ST_AREF;
         end
         ST_PRE: begin
            t_load  = 1'b1;
            t_val   = RP_LD;
            state_d = RP_SHORT ? ST_AREF : ST_WAIT_RP;
         end
         ST_WAIT_RP: begin
            if (t_expired) state_d = ST_AREF;
         end
         ST_AREF: begin
            t_load = 1'b1;
            t_val  = RFC_LD;
            if (RFC_SHORT) state_d = last ? ST_IDLE : ST_AREF;
            else           state_d = ST_WAIT_RFC;
         end
         ST_WAIT_RFC: begin
            if (t_expired) state_d = last ? ST_IDLE : ST_AREF;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= rfc_end && last;
         if (accept) begin
            rem_q <= (count == '0) ? '0 : count - 1'b1;
         end else if (rfc_end && !last) begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign state = state_q;
   assign done  = done_q;

endmodule

// File: rtl/refseq_encode.sv
module refseq_encode
   import refseq_pkg::*;
#(
   parameter bit FILL_DESELECT = 1'b0
) (
   input  seq_state_e  state,
   output logic [3:0]  cmd,
   output logic        a10,
   output logic        cke
);

   logic [3:0] filler;

   generate
      if (FILL_DESELECT) begin : g_fill_desl
         assign filler = CMD_DESL;
      end else begin : g_fill_nop
         assign filler = CMD_NOP;
      end
   endgenerate

   always_comb begin
      cmd = filler;
      a10 = 1'b0;
      unique case (state)
         ST_PRE: begin
            cmd = CMD_PRE;
            a10 = 1'b1;
         end
         ST_AREF: cmd = CMD_AREF;
         default: cmd = filler;
      endcase
   end

   assign cke = 1'b1;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import refseq_pkg::*;
#(
   parameter int T_RP          = 3,
   parameter int T_RFC         = 5,
   parameter int CNT_W         = 4,
   parameter bit FILL_DESELECT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_i,
   input  logic             bank_open_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [3:0]       cmd_o,
   output logic             a10_o,
   output logic             cke_o,
   output logic             done_o
);

   localparam int TMAX = max_of(T_RP, T_RFC);
   localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);

   generate
      if (T_RP < 1) begin : g_bad_rp
         $error("T_RP must be at least 1");
      end
      if (T_RFC < 1) begin : g_bad_rfc
         $error("T_RFC must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   seq_state_e     state_w;
   logic           t_load_w;
   logic [TW-1:0]  t_val_w;
   logic           t_exp_w;
   logic           idle_w;

   refseq_fsm #(
      .T_RP  (T_RP),
      .T_RFC (T_RFC),
      .CNT_W (CNT_W),
      .TW    (TW)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req       (req_i),
      .bank_open (bank_open_i),
      .count     (count_i),
      .t_expired (t_exp_w),
      .t_load    (t_load_w),
      .t_val     (t_val_w),
      .state     (state_w),
      .done      (done_o)
   );

   refseq_timer #(
      .WIDTH (TW)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load_w),
      .load_val (t_val_w),
      .expired  (t_exp_w)
   );

   refseq_encode #(
      .FILL_DESELECT (FILL_DESELECT)
   ) u_enc (
      .state (state_w),
      .cmd   (cmd_o),
      .a10   (a10_o),
      .cke   (cke_o)
   );

   assign idle_w = (state_w == ST_IDLE);

endmodule

// File: rtl/refseq_chk.sv
module refseq_chk
   import refseq_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 5
) (
   input logic       clk,
   input logic       rst,
   input logic       req_i,
   input logic       bank_open_i,
   input logic [3:0] cmd_o,
   input logic       a10_o,
   input logic       done_o,
   input logic       idle
);

   int unsigned since_pre;
   int unsigned since_aref;
   logic        quiet;

   assign quiet = (cmd_o == CMD_NOP) || cmd_o[3];

   always_ff @(posedge clk) begin
      if (rst) begin
         since_pre  <= T_RP;
         since_aref <= T_RFC;
      end else begin
         if (cmd_o == CMD_PRE)            since_pre <= 1;
         else if (since_pre < T_RP)       since_pre <= since_pre + 1;
         if (cmd_o == CMD_AREF)           since_aref <= 1;
         else if (since_aref < T_RFC)     since_aref <= since_aref + 1;
      end
   end

   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
      (cmd_o == CMD_PRE) |-> a10_o);                              // R2
   AST_OPEN_PRECHARGES: assert property (@(posedge clk) disable iff (rst)
      (idle && req_i && bank_open_i) |=> (cmd_o == CMD_PRE));     // R2
   AST_RP_QUIET: assert property (@(posedge clk) disable iff (rst)
      (since_pre < T_RP) |-> quiet);                              // R3
   AST_CLOSED_SKIPS_PRE: assert property (@(posedge clk) disable iff (rst)
      (idle && req_i && !bank_open_i) |=> (cmd_o == CMD_AREF));   // R4
   AST_RFC_QUIET: assert property (@(posedge clk) disable iff (rst)
      (since_aref < T_RFC) |-> quiet);                            // R5
   AST_DONE_AFTER_RFC: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (since_aref == T_RFC));                          // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);                                        // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> idle);                                           // R7
   AST_A10_LOW: assert property (@(posedge clk) disable iff (rst)
      (cmd_o != CMD_PRE) |-> !a10_o);                             // R10

endmodule

bind dram_refresh_seq refseq_chk #(
   .T_RP  (T_RP),
   .T_RFC (T_RFC)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_i       (req_i),
   .bank_open_i (bank_open_i),
   .cmd_o       (cmd_o),
   .a10_o       (a10_o),
   .done_o      (done_o),
   .idle        (idle_w)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

   localparam int T_RP  = 3;
   localparam int T_RFC = 5;
   localparam int CNT_W = 4;

   localparam logic [3:0] E_NOP  = 4'b0111;
   localparam logic [3:0] E_PRE  = 4'b0010;
   localparam logic [3:0] E_AREF = 4'b0001;

   typedef struct packed {
      logic             open;
      logic [CNT_W-1:0] n;
      logic [7:0]       nar;
      logic             poke;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 4'd1,  8'd1,  1'b0},
      '{1'b0, 4'd1,  8'd1,  1'b0},
      '{1'b1, 4'd3,  8'd3,  1'b0},
      '{1'b0, 4'd2,  8'd2,  1'b0},
      '{1'b0, 4'd0,  8'd1,  1'b0},
      '{1'b1, 4'd15, 8'd15, 1'b0},
      '{1'b1, 4'd2,  8'd2,  1'b1}
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             req = 1'b0;
   logic             bank_open = 1'b0;
   logic [CNT_W-1:0] count = '0;
   logic [3:0]       cmd;
   logic             a10, cke, done;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   dram_refresh_seq #(
      .T_RP  (T_RP),
      .T_RFC (T_RFC),
      .CNT_W (CNT_W)
   ) uut (
      .clk         (clk),
      .rst         (rst),
      .req_i       (req),
      .bank_open_i (bank_open),
      .count_i     (count),
      .cmd_o       (cmd),
      .a10_o       (a10),
      .cke_o       (cke),
      .done_o      (done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [3:0] ecmd,
                      input logic ea10, input logic edone);
      n_chk++;
      if (cmd !== ecmd) begin
         n_fail++;
         $display("FAIL %s cmd: act=%b exp=%b", tag, cmd, ecmd);
      end
      n_chk++;
      if (a10 !== ea10) begin
         n_fail++;
         $display("FAIL %s/R10 a10: act=%b exp=%b", tag, a10, ea10);
      end
      n_chk++;
      if (cke !== 1'b1) begin
         n_fail++;
         $display("FAIL R9 cke: act=%b exp=1", cke);
      end
      n_chk++;
      if (done !== edone) begin
         n_fail++;
         $display("FAIL %s/R7 done: act=%b exp=%b", tag, done, edone);
      end
   endtask

   // Checks every cycle of one sequence from acceptance until one cycle past done.
   task automatic run_seq(input logic open, input logic [CNT_W-1:0] n,
                          input int nar, input logic poke);
      int pre_off;
      int last;
      pre_off = open ? T_RP : 0;
      last    = pre_off + 1 + nar * T_RFC;
      req = 1'b1; bank_open = open; count = n;
      @(negedge clk);
      req = 1'b0; bank_open = ~open;
      for (int k = 1; k <= last; k++) begin
         logic [3:0] ecmd;
         logic       ea10, edone;
         string      tag;
         ecmd = E_NOP; ea10 = 1'b0; edone = (k == last);
         tag  = poke ? "R8" : (open ? "R3" : "R4");
         if (open && k == 1) begin
            ecmd = E_PRE; ea10 = 1'b1; tag = "R2";
         end else if (k > pre_off && ((k - pre_off - 1) % T_RFC) == 0 &&
                      ((k - pre_off - 1) / T_RFC) < nar) begin
            ecmd = E_AREF; tag = (k == pre_off + 1) ? (open ? "R3" : "R4") : "R6";
         end else if (k > pre_off + 1) begin
            tag = poke ? "R8" : "R5";
         end
         chk(tag, ecmd, ea10, edone);
         if (poke && (k == 2 || k == pre_off + 2)) begin
            req = 1'b1; count = 4'd9; bank_open = 1'b1;
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
      end
      req = 1'b0;
      chk("R7", E_NOP, 1'b0, 1'b0);
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", E_NOP, 1'b0, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", E_NOP, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         run_seq(VECS[i].open, VECS[i].n, int'(VECS[i].nar), VECS[i].poke);
         @(negedge clk);
      end

      // R1: reset in the middle of a chained sequence
      req = 1'b1; bank_open = 1'b1; count = 4'd3;
      @(negedge clk);
      req = 1'b0;
      repeat (6) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", E_NOP, 1'b0, 1'b0);
      rst = 1'b0;
      repeat (T_RFC + 2) begin
         @(negedge clk);
         chk("R1", E_NOP, 1'b0, 1'b0);
      end

      // R4/R6: recovery after reset with a fresh sequence
      run_seq(1'b0, 4'd2, 2, 1'b0);

      // R8: back-to-back request accepted right after done, in idle
      run_seq(1'b1, 4'd1, 1, 1'b0);
      run_seq(1'b0, 4'd1, 1, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule